// File: doc/BRIEF.md
# Mode-Switchable UART Receive Buffer

This block is the receive side of a 16550-style serial port: it holds incoming characters and reports line status to the host. Characters arrive one per cycle on a push port, from the deserializer or from a loopback path. The host removes them by reading the data register, which pulses the pop strobe. The buffer is circular. It works in one of two modes chosen by software through the FIFO control value. With FIFO mode off it acts as a single holding register. With FIFO mode on it holds up to `DEPTH` (16) characters.

Changing the mode empties the buffer. A receive-reset request made while FIFO mode is on also empties it. When a character arrives and no slot is free, the character is lost and an overrun flag is raised. The line-status value reports that flag together with data-ready and the two transmitter-ready bits. The overrun flag clears once the status has been read.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the stored FCR value is 0x00, the buffer holds at most one character, the line-status value reads 0x60 and the pop data reads 0x00.
- R2: An FCR write whose bit 0 (FIFO enable) differs from the stored bit 0 empties the buffer. The usable depth then becomes 16 if bit 0 is 1, or 1 if bit 0 is 0.
- R3: An FCR write with bit 0 clear stores 0x00, whatever its other bits hold.
- R4: An FCR write with bit 0 set and bit 1 (receive reset) set empties the buffer and leaves the usable depth at 16.
- R5: An FCR write with bit 0 set stores only bits 7, 6, 3 and 0 of the written value, so the stored value is the written value ANDed with 0xC9.
- R6: A push while the buffer is at its usable depth, with no pop in the same cycle, is dropped and sets line-status bit 1 (overrun).
- R7: Line-status bits 6 and 5 always read 1. Bit 0 is 1 exactly when the buffer is non-empty. Bits 7, 4, 3 and 2 read 0.
- R8: The overrun bit is visible on the cycle the line-status read strobe is high. It is 0 from the next cycle on, unless a new overrun occurs in that same cycle.
- R9: A pop of an empty buffer returns 0x00 and does not change the buffer contents or pointers.
- R10: Characters leave in arrival order. The pointers wrap modulo the usable depth, so 16 characters fit in FIFO mode whatever the pointer position.
- R11: A push and a pop in the same cycle on a full buffer both take effect with no overrun. An FCR write that empties the buffer discards any push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Incoming character strobe |
| push_data | input | 8 | Incoming character |
| pop_req | input | 1 | Data-register read strobe; removes the oldest character |
| pop_data | output | 8 | Oldest character, or 0x00 when empty |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| fcr_value | output | 8 | Stored FIFO control value |
| lsr_rd | input | 1 | Line-status read strobe |
| lsr_value | output | 8 | Line-status value |

## Verification
`pop_data` and `lsr_value` come combinationally from registered state. Their values in a cycle are therefore the result of the strobe cycle before, and a read strobe returns what is shown during its own cycle. Pushes, pops, FCR writes and the overrun clear all take effect at the edge that ends the strobe cycle. They are visible one cycle later.

The bench drives every strobe for exactly one cycle from a falling edge. It samples outputs at the falling edge that follows: pop data and status are compared before a strobe is raised, and state changes are compared one full cycle after it.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
    // FIFO control bit positions
    localparam int FCR_EN_BIT    = 0;
    localparam int FCR_RXRST_BIT = 1;
    localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;

    // Line-status bit positions
    localparam int LSR_DR_BIT   = 0;
    localparam int LSR_OE_BIT   = 1;
    localparam int LSR_THRE_BIT = 5;
    localparam int LSR_TEMT_BIT = 6;
endpackage

// File: rtl/uart_rxb_fcr_dec.sv
module uart_rxb_fcr_dec
    import uart_rxb_pkg::*;
(
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic [7:0] cur,
    output logic [7:0] next_fcr,
    output logic       flush
);
    logic mode_flip;
    logic rx_reset;

    always_comb begin
        mode_flip = wdata[FCR_EN_BIT] != cur[FCR_EN_BIT];
        rx_reset  = wdata[FCR_EN_BIT] && wdata[FCR_RXRST_BIT];
        flush     = wr && (mode_flip || rx_reset);
        if (!wr) begin
            next_fcr = cur;
        end else if (wdata[FCR_EN_BIT]) begin
            next_fcr = wdata & FCR_KEEP_MASK;
        end else begin
            next_fcr = 8'h00;
        end
    end
endmodule

// File: rtl/uart_rxb_store.sv
module uart_rxb_store #(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [7:0]       rd_data
);
    logic [7:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == PTR_W'(i))) begin
                slot_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_ptr];
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    input  logic       pop_req,
    output logic [7:0] pop_data,
    input  logic       fcr_wr,
    input  logic [7:0] fcr_wdata,
    output logic [7:0] fcr_value,
    input  logic       lsr_rd,
    output logic [7:0] lsr_value
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             overrun;
        logic [7:0]       fcr;
    } rxb_state_t;

    rxb_state_t st_d, st_q;

    logic [7:0]       fcr_next_d;
    logic             flush_d;
    logic [CNT_W-1:0] cap_d;
    logic             do_push_d, do_pop_d;
    logic [7:0]       head_data;
    logic [CNT_W-1:0] occ_q;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] lim);
        if ((CNT_W'(p) + CNT_W'(1)) >= lim) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    uart_rxb_fcr_dec u_fcr (
        .wr       (fcr_wr),
        .wdata    (fcr_wdata),
        .cur      (st_q.fcr),
        .next_fcr (fcr_next_d),
        .flush    (flush_d)
    );

    uart_rxb_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (do_push_d),
        .wr_ptr  (st_q.wr_ptr),
        .wr_data (push_data),
        .rd_ptr  (st_q.rd_ptr),
        .rd_data (head_data)
    );

    always_comb begin
        st_d      = st_q;
        cap_d     = st_q.fcr[FCR_EN_BIT] ? CNT_W'(DEPTH) : CNT_W'(1);
        do_pop_d  = 1'b0;
        do_push_d = 1'b0;
        st_d.fcr  = fcr_next_d;
        if (lsr_rd) begin
            st_d.overrun = 1'b0;
        end
        if (flush_d) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            do_pop_d  = pop_req && (st_q.count != '0);
            do_push_d = push_valid && ((st_q.count < cap_d) || do_pop_d);
            if (do_pop_d) begin
                st_d.rd_ptr = ptr_step(st_q.rd_ptr, cap_d);
            end
            if (do_push_d) begin
                st_d.wr_ptr = ptr_step(st_q.wr_ptr, cap_d);
            end
            st_d.count = st_q.count + CNT_W'(do_push_d) - CNT_W'(do_pop_d);
            if (push_valid && !do_push_d) begin
                st_d.overrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        lsr_value               = 8'h00;
        lsr_value[LSR_TEMT_BIT] = 1'b1;
        lsr_value[LSR_THRE_BIT] = 1'b1;
        lsr_value[LSR_OE_BIT]   = st_q.overrun;
        lsr_value[LSR_DR_BIT]   = st_q.count != '0;
    end

    assign pop_data  = (st_q.count != '0) ? head_data : 8'h00;
    assign fcr_value = st_q.fcr;
    assign occ_q     = st_q.count;
endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             pop_req,
    input logic             fcr_wr,
    input logic [7:0]       fcr_wdata,
    input logic [7:0]       fcr_value,
    input logic             lsr_rd,
    input logic [7:0]       lsr_value,
    input logic [7:0]       pop_data,
    input logic [CNT_W-1:0] occ_q
);
    logic [CNT_W-1:0] cap;
    assign cap = fcr_value[0] ? CNT_W'(DEPTH) : CNT_W'(1);

    // R1
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fcr_value[0] |-> occ_q <= CNT_W'(1));

    // R10
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= cap);

    // R2
    mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && (fcr_wdata[0] != fcr_value[0]) |=> occ_q == '0);

    // R3
    disable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && !fcr_wdata[0] |=> fcr_value == 8'h00);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !pop_req && !fcr_wr && (occ_q == cap) |=> lsr_value[1]);

    // R8
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !push_valid |=> !lsr_value[1]);

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && (occ_q == '0) && !push_valid && !fcr_wr |=> (occ_q == '0) && (pop_data == 8'h00));
endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .fcr_wr     (fcr_wr),
    .fcr_wdata  (fcr_wdata),
    .fcr_value  (fcr_value),
    .lsr_rd     (lsr_rd),
    .lsr_value  (lsr_value),
    .pop_data   (pop_data),
    .occ_q      (occ_q)
);

// File: tb/uart_rx_buffer_test.sv
module uart_rx_buffer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_wdata = 8'h00;
    logic [7:0] fcr_value;
    logic       lsr_rd = 1'b0;
    logic [7:0] lsr_value;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_rx_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data),
        .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .fcr_value(fcr_value),
        .lsr_rd(lsr_rd), .lsr_value(lsr_value)
    );

    // Vector ops: 0 push, 1 pop and compare data, 2 FCR write, 3 status read and compare
    localparam logic [17:0] VEC [12] = '{
        {2'd0, 8'hA1, 8'h00}, {2'd0, 8'hA2, 8'h00}, {2'd0, 8'hA3, 8'h00},
        {2'd3, 8'h00, 8'h61}, {2'd1, 8'h00, 8'hA1}, {2'd0, 8'hA4, 8'h00},
        {2'd1, 8'h00, 8'hA2}, {2'd1, 8'h00, 8'hA3}, {2'd1, 8'h00, 8'hA4},
        {2'd1, 8'h00, 8'h00}, {2'd3, 8'h00, 8'h60}, {2'd2, 8'hC1, 8'h00}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_push(logic [7:0] b);
        push_valid = 1'b1; push_data = b;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic do_pop(string req, logic [7:0] exp);
        check(req, pop_data, exp);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic do_fcr(logic [7:0] v);
        fcr_wr = 1'b1; fcr_wdata = v;
        @(negedge clk);
        fcr_wr = 1'b0;
    endtask

    task automatic do_lsr(string req, logic [7:0] exp);
        check(req, lsr_value, exp);
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 fcr", fcr_value, 8'h00);
        check("R1 lsr", lsr_value, 8'h60);
        check("R1 pop", pop_data, 8'h00);

        // R6 R8 single-slot overrun
        do_push(8'h11);
        do_push(8'h22);
        do_lsr("R6 overrun", 8'h63);
        do_lsr("R8 cleared", 8'h61);
        do_pop("R6 first kept", 8'h11);
        do_pop("R9 empty pop", 8'h00);
        do_lsr("R7 empty", 8'h60);

        // R2 enable flushes
        do_push(8'h33);
        do_fcr(8'h01);
        check("R2 fcr", fcr_value, 8'h01);
        do_lsr("R2 flushed", 8'h60);

        // table walk in FIFO mode
        for (int i = 0; i < 12; i++) begin
            case (VEC[i][17:16])
                2'd0: do_push(VEC[i][15:8]);
                2'd1: do_pop("R10 vec", VEC[i][7:0]);
                2'd2: do_fcr(VEC[i][15:8]);
                default: do_lsr("R7 vec", VEC[i][7:0]);
            endcase
        end
        check("R4 fcr", fcr_value, 8'hC1);

        // R10 wrap then fill 16
        for (int i = 0; i < 5; i++) do_push(8'h70 + 8'(i));
        for (int i = 0; i < 5; i++) do_pop("R10 pre", 8'h70 + 8'(i));
        for (int i = 0; i < 16; i++) do_push(8'h40 + 8'(i));
        do_lsr("R10 full no overrun", 8'h61);
        // R11 push and pop together on full
        push_valid = 1'b1; push_data = 8'h99;
        do_pop("R11 head", 8'h40);
        push_valid = 1'b0;
        do_lsr("R11 no overrun", 8'h61);
        do_push(8'hEE);
        do_lsr("R6 fifo overrun", 8'h63);
        for (int i = 1; i < 16; i++) do_pop("R10 order", 8'h40 + 8'(i));
        do_pop("R11 tail", 8'h99);
        do_lsr("R7 drained", 8'h60);

        // R4 receive reset
        do_push(8'h01); do_push(8'h02);
        do_fcr(8'h03);
        do_lsr("R4 flushed", 8'h60);
        do_push(8'h05);
        do_fcr(8'h0D);
        check("R5 mask", fcr_value, 8'h09);
        do_pop("R5 no flush", 8'h05);
        do_fcr(8'hFD);
        check("R5 mask all", fcr_value, 8'hC9);

        // R3 disable with other bits set, plus same-cycle push discarded (R11)
        do_push(8'h66);
        fcr_wr = 1'b1; fcr_wdata = 8'hFE; push_valid = 1'b1; push_data = 8'h77;
        @(negedge clk);
        fcr_wr = 1'b0; push_valid = 1'b0;
        check("R3 fcr zero", fcr_value, 8'h00);
        do_lsr("R11 flush drops push", 8'h60);
        do_push(8'h81); do_push(8'h82);
        do_lsr("R2 depth one", 8'h63);
        do_pop("R2 depth one data", 8'h81);

        finish_run();
    end
endmodule